// File: doc/BRIEF.md
# Clock Controller Configuration Register Bank

This block holds the configuration state of a clock controller: one mode register, two post-divider registers, two PLL control registers, three clock-gate registers and one power-management register. Software reaches it over a plain word-addressed bus that has a read strobe, a write strobe, an address, write data and registered read data. Each register loads a fixed value on reset. On a write, each register keeps only the bits that its own mask lets through, and the mode register also sets one bit that is always forced on.

Every register value is driven out continuously to a downstream frequency calculator. When a write lands in a register that changes clock frequencies, the bank raises a one-cycle `recompute` pulse so that the calculator can refresh its results. The bank raises the same pulse once when reset is released, so the calculator starts from the reset contents. Writes to the clock-gate registers do not raise the pulse. One unmapped read location returns a fixed pattern.

Top module: `clkctl_regbank`

## Requirements
- R1: While reset is held, and after it, the exports show mode 0x074b0b7b, post-divider 0 0xff870b48, post-divider 1 0x49fcfe7f, main PLL 0x04001800, secondary PLL 0x04043001, all three gates 0xffffffff and power-management 0x80209828.
- R2: Read data appears on `bus_rdata` in the cycle after the one where `bus_rd` is sampled high, and holds its value when no read is made. The word indices are: mode 0, post-divider 0 at 1, post-divider 1 at 2, main PLL 4, secondary PLL 6, gates 8/9/10, power-management 23. A read in the same cycle as a write returns the old value.
- R3: A write to index 0 stores (wdata & 0x3b6fdfff) | 0x04000000, so bit 26 of the mode register is always 1.
- R4: A write to index 1 stores wdata & 0xff9f3fff. A write to index 2 stores the full word.
- R5: A write to index 4 or index 6 stores wdata & 0xbfff3fff.
- R6: Writes to indices 8, 9 and 10 store the full word and raise no `recompute` pulse.
- R7: A write to index 0, 1, 2, 4 or 6 sets `recompute` high for exactly the next cycle. Back-to-back writes keep it high for one cycle per write.
- R8: `recompute` is high for the one cycle after the first clock edge at which reset is sampled low.
- R9: A read of index 18 returns 0x00004040. A read of any other unmapped index returns 0.
- R10: Writes to index 23 or to any unmapped index change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (10) | Word index |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| recompute | output | 1 | One-cycle request to recompute frequencies |
| cfg_mode | output | 32 | Mode register value |
| cfg_div0 | output | 32 | Post-divider 0 value |
| cfg_div1 | output | 32 | Post-divider 1 value |
| cfg_mpll | output | 32 | Main PLL control value |
| cfg_spll | output | 32 | Secondary PLL control value |
| cfg_gate | output | 96 | Gate registers; gate 0 in bits 31:0 |
| cfg_pmr | output | 32 | Power-management value |

## Verification
The assertions take the bus strobes and the address to be known, non-X values on every clock edge outside reset. They also expect reset to be applied at time zero, so that `$fell(rst)` marks a real release. The bench drives every input on the falling edge from a single process, keeps reset high from the start, and picks addresses only from a list of defined values, some mapped and some not. It mixes overlapping reads and writes, back-to-back writes and idle cycles, and never leaves a strobe floating.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int WORD_W = 32;
  localparam int NSLOT  = 9;
  typedef logic [WORD_W-1:0] word_t;

  // slot order: mode, div0, div1, mpll, spll, gate0..2, pmr
  localparam int unsigned SLOT_IDX [NSLOT] = '{0, 1, 2, 4, 6, 8, 9, 10, 23};
  localparam word_t SLOT_RST [NSLOT] = '{
    32'h074b0b7b, 32'hff870b48, 32'h49fcfe7f, 32'h04001800, 32'h04043001,
    32'hffffffff, 32'hffffffff, 32'hffffffff, 32'h80209828};
  localparam word_t SLOT_MASK [NSLOT] = '{
    32'h3b6fdfff, 32'hff9f3fff, 32'hffffffff, 32'hbfff3fff, 32'hbfff3fff,
    32'hffffffff, 32'hffffffff, 32'hffffffff, 32'h00000000};
  localparam word_t SLOT_FORCE [NSLOT] = '{
    32'h04000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  // bit i refers to slot i
  localparam logic [NSLOT-1:0] SLOT_WRITABLE = 9'b0_1111_1111;
  localparam logic [NSLOT-1:0] SLOT_RECALC   = 9'b0_0001_1111;

  localparam int unsigned CONST_IDX = 18;
  localparam word_t       CONST_VAL = 32'h00004040;
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  hit,
  output logic              const_hit
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign hit[i] = (addr == ADDR_W'(SLOT_IDX[i]));
  end
  assign const_hit = (addr == ADDR_W'(CONST_IDX));
endmodule

// File: rtl/clkctl_cell.sv
module clkctl_cell
  import clkctl_pkg::*;
#(
  parameter word_t RST_VAL  = '0,
  parameter word_t MASK     = '1,
  parameter word_t FORCE    = '0,
  parameter bit    WRITABLE = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);
  word_t nxt;
  assign nxt = WRITABLE ? ((wdata & MASK) | FORCE) : q;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= nxt;
  end

  // R1: reset loads the fixed value
  assert_reset_load_R1: assert property (@(posedge clk) rst |=> q == RST_VAL);
  // R3 R4 R5: after a write, no bit outside mask or forced set survives
  assert_unmasked_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (we && WRITABLE) |=> ((q & ~MASK & ~FORCE) == '0));
endmodule

// File: rtl/clkctl_rdport.sv
module clkctl_rdport
  import clkctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd,
  input  logic [NSLOT-1:0]       hit,
  input  logic                   const_hit,
  input  logic [NSLOT-1:0][WORD_W-1:0] vals,
  output word_t                  rdata
);
  word_t sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NSLOT; i++)
      if (hit[i]) sel = sel | vals[i];
    if (const_hit) sel = CONST_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                recompute,
  output logic [31:0]         cfg_mode,
  output logic [31:0]         cfg_div0,
  output logic [31:0]         cfg_div1,
  output logic [31:0]         cfg_mpll,
  output logic [31:0]         cfg_spll,
  output logic [95:0]         cfg_gate,
  output logic [31:0]         cfg_pmr
);
  logic [NSLOT-1:0]             hit;
  logic                         const_hit;
  logic [NSLOT-1:0][WORD_W-1:0] vals;
  logic                         boot_pending;
  logic                         wr_recalc;

  clkctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .const_hit(const_hit));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    clkctl_cell #(
      .RST_VAL (SLOT_RST[i]),
      .MASK    (SLOT_MASK[i]),
      .FORCE   (SLOT_FORCE[i]),
      .WRITABLE(SLOT_WRITABLE[i])
    ) u_cell (
      .clk(clk), .rst(rst), .we(bus_wr && hit[i]),
      .wdata(bus_wdata), .q(vals[i]));
  end

  clkctl_rdport u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .hit(hit), .const_hit(const_hit),
    .vals(vals), .rdata(bus_rdata));

  assign wr_recalc = bus_wr && |(hit & SLOT_RECALC);

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pending <= 1'b1;
      recompute    <= 1'b0;
    end else begin
      boot_pending <= 1'b0;
      recompute    <= boot_pending | wr_recalc;
    end
  end

  assign cfg_mode = vals[0];
  assign cfg_div0 = vals[1];
  assign cfg_div1 = vals[2];
  assign cfg_mpll = vals[3];
  assign cfg_spll = vals[4];
  assign cfg_gate = {vals[7], vals[6], vals[5]};
  assign cfg_pmr  = vals[8];

  assert_mode_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> recompute);
  assert_gate_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !boot_pending && bus_addr >= ADDR_W'(8) && bus_addr <= ADDR_W'(10))
    |=> !recompute);
  assert_boot_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> recompute);
  assert_const_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(CONST_IDX)) |=> bus_rdata == CONST_VAL);
  assert_pmr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(23)) |=> $stable(cfg_pmr));
  assert_force_bit_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_mode[26]);
endmodule

// File: tb/sim_clkctl_regbank.sv
`timescale 1ns/1ps
module sim_clkctl_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        recompute;
  logic [31:0] cfg_mode, cfg_div0, cfg_div1, cfg_mpll, cfg_spll, cfg_pmr;
  logic [95:0] cfg_gate;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] regs [0:31];
  logic [31:0] exp_rdata = '0;
  bit exp_rec;

  always #10 clk = ~clk;

  clkctl_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .recompute(recompute),
    .cfg_mode(cfg_mode), .cfg_div0(cfg_div0), .cfg_div1(cfg_div1),
    .cfg_mpll(cfg_mpll), .cfg_spll(cfg_spll), .cfg_gate(cfg_gate), .cfg_pmr(cfg_pmr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic bit mapped(int a);
    return a inside {0, 1, 2, 4, 6, 8, 9, 10, 23};
  endfunction

  function automatic logic [31:0] model_read(int a);
    if (a == 18) return 32'h00004040;
    if (mapped(a)) return regs[a];
    return 32'h0;
  endfunction

  // returns 1 when the write should request a recompute
  function automatic bit model_write(int a, logic [31:0] d);
    case (a)
      0:       begin regs[0] = (d & 32'h3b6fdfff) | 32'h04000000; return 1; end
      1:       begin regs[1] = d & 32'hff9f3fff; return 1; end
      2:       begin regs[2] = d; return 1; end
      4, 6:    begin regs[a] = d & 32'hbfff3fff; return 1; end
      8, 9, 10: begin regs[a] = d; return 0; end
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) regs[i] = '0;
    regs[0] = 32'h074b0b7b; regs[1] = 32'hff870b48; regs[2] = 32'h49fcfe7f;
    regs[4] = 32'h04001800; regs[6] = 32'h04043001;
    regs[8] = '1; regs[9] = '1; regs[10] = '1; regs[23] = 32'h80209828;
  endtask

  task automatic check_exports(string tag);
    check({tag, " R3 mode"}, cfg_mode, regs[0]);
    check({tag, " R4 div0"}, cfg_div0, regs[1]);
    check({tag, " R4 div1"}, cfg_div1, regs[2]);
    check({tag, " R5 mpll"}, cfg_mpll, regs[4]);
    check({tag, " R5 spll"}, cfg_spll, regs[6]);
    check({tag, " R6 gate0"}, cfg_gate[31:0], regs[8]);
    check({tag, " R6 gate1"}, cfg_gate[63:32], regs[9]);
    check({tag, " R6 gate2"}, cfg_gate[95:64], regs[10]);
    check({tag, " R10 pmr"}, cfg_pmr, regs[23]);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit rd, bit wr, int a, logic [31:0] d, string tag);
    bus_rd = rd; bus_wr = wr; bus_addr = 10'(a); bus_wdata = d;
    @(posedge clk);
    if (rd) exp_rdata = model_read(a);
    exp_rec = wr ? model_write(a, d) : 1'b0;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check({tag, " R2 rdata"}, bus_rdata, exp_rdata);
    check({tag, " R7 recompute"}, {31'b0, recompute}, {31'b0, exp_rec});
    check_exports(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_exports("R1 reset");
    check("R1 recompute low in reset", {31'b0, recompute}, 32'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 boot pulse", {31'b0, recompute}, 32'h1);
    check_exports("R1 after release");
    step(0, 0, 0, 0, "R8 pulse ends");

    for (int a = 0; a < 32; a++) step(1, 0, a, 0, "R9 R1 read sweep");
    step(1, 0, 700, 0, "R9 high unmapped");

    step(0, 1, 0, 32'hffffffff, "R3 mode ones");
    step(1, 1, 0, 32'h00000000, "R3 mode zero, R2 old value");
    step(1, 0, 0, 0, "R3 read forced bit");
    step(0, 1, 1, 32'hffffffff, "R4 div0");
    step(0, 1, 2, 32'h12345678, "R4 div1");
    step(0, 1, 4, 32'hffffffff, "R5 mpll");
    step(0, 1, 6, 32'h55aa55aa, "R5 spll");
    step(0, 1, 8, 32'h0, "R6 gate0");
    step(0, 1, 9, 32'hdeadbeef, "R6 gate1");
    step(0, 1, 10, 32'h0f0f0f0f, "R6 gate2");
    step(0, 1, 23, 32'h0, "R10 pmr write");
    step(1, 1, 18, 32'h0, "R10 R9 const write");
    step(0, 1, 3, 32'hffffffff, "R10 hole");
    step(0, 1, 513, 32'hffffffff, "R10 far");
    for (int a = 0; a < 32; a++) step(1, 0, a, 0, "R2 sweep after writes");

    for (int n = 0; n < 600; n++) begin
      int pick[14] = '{0, 1, 2, 3, 4, 6, 8, 9, 10, 18, 23, 31, 5, 300};
      int a = pick[$urandom_range(0, 13)];
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, $urandom(),
           "R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule